// File: doc/BRIEF.md
# Instruction Stream Prefetch Buffer

A small line buffer that sits next to an L1 instruction cache and fetches ahead of the instruction stream. Every fetch address probes the buffer in the same cycle as the cache lookup. If the cache misses and the buffer holds the line, the line is handed to the cache on the fill port one cycle later. If both miss, the block sends a demand read to L2 and restarts sequential prefetching at the line after the missing one. After that, whenever the shared single-ported L2 bus is free of demand traffic, it fetches consecutive lines into free slots.

Two lookup policies are available, and the choice is taken at reset. In the ordered mode the buffer is a queue: only its head is compared, and any miss empties it. In the associative mode every entry is compared, and each entry carries a reusable flag that decides where the next prefetch may land, using least-recently-used order. A demand miss that finds the bus held by a prefetch waits for that transfer to finish. Each cycle it waits is added to a wasted-cycle counter.

Top module: `ifetch_sbuf`

## Requirements
- R1: `probe_hit_o` rises in the same cycle as an accepted probe whose line is present with its data. In ordered mode (mode 0) only the head entry is compared. In associative mode (mode 1) all entries are compared.
- R2: A hit while `icache_hit_i` is 0 drives `fill_valid_o` on the next cycle, with the probed address and that line's data. A hit while `icache_hit_i` is 1 changes nothing.
- R3: In ordered mode, an accepted probe that misses both the cache and the head empties the queue and discards any prefetch in flight. Prefetching then resumes at the missing line address plus one. A transfer pops the head.
- R4: In associative mode a miss marks every entry reusable and moves the prefetch pointer to the missing line plus one. A transferred entry becomes reusable and most recent. A prefetch goes only into the reusable entry used least recently, and only if such an entry exists. An address already held is skipped, which costs one cycle.
- R5: After a double miss, a demand request (`l2_req_pf_o` = 0) goes out on the first cycle after the miss in which the bus is idle. Its response appears on the fill port one cycle after `l2_resp_valid_i`.
- R6: A prefetch request goes out only in a cycle with all of the following: the bus is idle, no demand is waiting, no miss is seen, no transfer takes place, prefetching has been started by a miss, and there is room. Only one transaction is outstanding at a time.
- R7: `harm_cnt_o` grows by one for each cycle in which a demand waits while a prefetch owns the bus.
- R8: A probe that matches an entry whose fill is still pending raises `probe_stall_o` instead of a miss. It issues no request and no flush.
- R9: From a miss until its demand response arrives, probes are ignored: no hit, no stall, no miss.
- R10: `mode_lru_i` is sampled only while `rst_n` is low. After reset the buffer is empty, all outputs are idle, and nothing is prefetched before the first miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_lru_i | input | 1 | Policy select, 0 ordered, 1 associative; sampled in reset |
| probe_valid_i | input | 1 | Fetch probe present |
| probe_addr_i | input | AW | Probed line address |
| icache_hit_i | input | 1 | L1 lookup result for this probe |
| probe_hit_o | output | 1 | Line ready in buffer |
| probe_stall_o | output | 1 | Line matched but still being filled |
| fill_valid_o | output | 1 | Line delivered to L1 |
| fill_addr_o | output | AW | Address of delivered line |
| fill_data_o | output | DW | Data of delivered line |
| l2_req_o | output | 1 | L2 read request, one cycle |
| l2_req_addr_o | output | AW | Requested line address |
| l2_req_pf_o | output | 1 | Request is a prefetch |
| l2_resp_valid_i | input | 1 | L2 response for the outstanding request |
| l2_resp_data_i | input | DW | Response data |
| harm_cnt_o | output | CW | Cycles a demand waited behind a prefetch |

## Verification
The hardest case to reach is a demand miss that arrives while a prefetch owns the bus. In ordered mode this also discards the in-flight fill. Reaching it needs a probe stream that jumps away from the sequential run just as a prefetch has launched. The stimulus mixes mostly sequential fetch addresses with rare random jumps inside a small window and varies the L2 latency per address. This produces these collisions, catch-up stalls on pending lines, and address reuse in associative mode. A behavioural queue/recency-list model runs alongside in both modes and is compared on every cycle.

// File: rtl/ifetch_sbuf.sv
`timescale 1ns/1ps
module ifetch_sbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_lru_i,
  input  logic          probe_valid_i,
  input  logic [AW-1:0] probe_addr_i,
  input  logic          icache_hit_i,
  output logic          probe_hit_o,
  output logic          probe_stall_o,
  output logic          fill_valid_o,
  output logic [AW-1:0] fill_addr_o,
  output logic [DW-1:0] fill_data_o,
  output logic          l2_req_o,
  output logic [AW-1:0] l2_req_addr_o,
  output logic          l2_req_pf_o,
  input  logic          l2_resp_valid_i,
  input  logic [DW-1:0] l2_resp_data_i,
  output logic [CW-1:0] harm_cnt_o
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW:0] DEP = (IW+1)'(DEPTH);
  localparam logic [1:0] B_IDLE = 2'd0, B_DEM = 2'd1, B_PF = 2'd2;

  logic              mode_q;
  logic [DEPTH-1:0]  vld, pnd, rpl;
  logic [AW-1:0]     tag_a [DEPTH];
  logic [DW-1:0]     line  [DEPTH];
  logic [IW-1:0]     age   [DEPTH];
  logic [IW-1:0]     head, pf_ix;
  logic [IW:0]       cnt;
  logic [AW-1:0]     nxt, dem_a;
  logic              pf_on, dem_w, drop;
  logic [1:0]        bus;
  logic              fill_v;
  logic [AW-1:0]     fill_a;
  logic [DW-1:0]     fill_d;
  logic [CW-1:0]     harm;

  logic          match, dup, has_rpl;
  logic [IW-1:0] hit_ix, vict, tail, slot, tch;
  logic [IW:0]   tsum;

  always_comb begin
    match = 1'b0; hit_ix = head; dup = 1'b0; has_rpl = 1'b0; vict = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && tag_a[i] == probe_addr_i && !match) begin
        match = 1'b1; hit_ix = IW'(i);
      end
      if (vld[i] && tag_a[i] == nxt) dup = 1'b1;
      if (rpl[i] && (!has_rpl || age[i] > age[vict])) begin
        has_rpl = 1'b1; vict = IW'(i);
      end
    end
    if (!mode_q) begin
      match  = vld[head] && tag_a[head] == probe_addr_i;
      hit_ix = head;
    end
  end

  assign tsum = {1'b0, head} + cnt;
  assign tail = (tsum >= DEP) ? IW'(tsum - DEP) : IW'(tsum);

  wire dem_out = dem_w | (bus == B_DEM);
  wire pv      = probe_valid_i & ~dem_out;
  wire hit     = pv & match & ~pnd[hit_ix];
  wire stall   = pv & ~icache_hit_i & match & pnd[hit_ix];
  wire miss    = pv & ~icache_hit_i & ~match;
  wire xfer    = hit & ~icache_hit_i;
  wire room    = mode_q ? has_rpl : (cnt < DEP);
  wire idle    = (bus == B_IDLE);
  wire dem_go  = idle & dem_w;
  wire pf_ok   = idle & ~dem_w & pf_on & ~miss & ~xfer & room;
  wire skip    = pf_ok & mode_q & dup;
  wire pf_go   = pf_ok & ~skip;
  wire resp    = l2_resp_valid_i & ~idle;
  wire touch   = mode_q & (pf_go | xfer);

  assign slot = mode_q ? vict : tail;
  assign tch  = pf_go ? slot : hit_ix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_lru_i;
      vld <= '0; pnd <= '0; rpl <= '1;
      for (int i = 0; i < DEPTH; i++) begin
        tag_a[i] <= '0; line[i] <= '0; age[i] <= IW'(i);
      end
      head <= '0; pf_ix <= '0; cnt <= '0; nxt <= '0; dem_a <= '0;
      pf_on <= 1'b0; dem_w <= 1'b0; drop <= 1'b0; bus <= B_IDLE;
      fill_v <= 1'b0; fill_a <= '0; fill_d <= '0; harm <= '0;
    end else begin
      fill_v <= 1'b0;
      if (dem_w && bus == B_PF) harm <= harm + 1'b1;

      if (resp) begin
        bus  <= B_IDLE;
        drop <= 1'b0;
        if (bus == B_DEM) begin
          fill_v <= 1'b1; fill_a <= dem_a; fill_d <= l2_resp_data_i;
        end else if (!drop) begin
          line[pf_ix] <= l2_resp_data_i; pnd[pf_ix] <= 1'b0;
        end
      end else if (dem_go) begin
        bus <= B_DEM; dem_w <= 1'b0;
      end else if (pf_go) begin
        bus <= B_PF; pf_ix <= slot;
        vld[slot] <= 1'b1; pnd[slot] <= 1'b1; rpl[slot] <= 1'b0;
        tag_a[slot] <= nxt; nxt <= nxt + 1'b1;
        if (!mode_q) cnt <= cnt + 1'b1;
      end
      if (skip) nxt <= nxt + 1'b1;

      if (xfer) begin
        fill_v <= 1'b1; fill_a <= tag_a[hit_ix]; fill_d <= line[hit_ix];
        if (mode_q) rpl[hit_ix] <= 1'b1;
        else begin
          vld[head] <= 1'b0;
          head <= (head == IW'(DEPTH-1)) ? '0 : head + 1'b1;
          cnt  <= cnt - 1'b1;
        end
      end

      if (touch)
        for (int i = 0; i < DEPTH; i++)
          if (IW'(i) == tch) age[i] <= '0;
          else if (age[i] < age[tch]) age[i] <= age[i] + 1'b1;

      if (miss) begin
        dem_w <= 1'b1; dem_a <= probe_addr_i;
        nxt <= probe_addr_i + 1'b1; pf_on <= 1'b1;
        if (mode_q) rpl <= '1;
        else begin
          vld <= '0; pnd <= '0; head <= '0; cnt <= '0;
          if (bus == B_PF && !resp) drop <= 1'b1;
        end
      end
    end
  end

  assign probe_hit_o   = hit;
  assign probe_stall_o = stall;
  assign fill_valid_o  = fill_v;
  assign fill_addr_o   = fill_a;
  assign fill_data_o   = fill_d;
  assign l2_req_o      = dem_go | pf_go;
  assign l2_req_addr_o = dem_go ? dem_a : nxt;
  assign l2_req_pf_o   = pf_go;
  assign harm_cnt_o    = harm;
endmodule

module ifetch_sbuf_chk #(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          probe_valid_i,
  input logic [AW-1:0] probe_addr_i,
  input logic          icache_hit_i,
  input logic          probe_hit_o,
  input logic          probe_stall_o,
  input logic          fill_valid_o,
  input logic [AW-1:0] fill_addr_o,
  input logic          l2_req_o,
  input logic          l2_req_pf_o,
  input logic [CW-1:0] harm_cnt_o
);
  p_fill_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid_i && !icache_hit_i && probe_hit_o |=>
      fill_valid_o && fill_addr_o == $past(probe_addr_i));
  p_hit_stall_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_hit_o && probe_stall_o));
  p_stall_no_dem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    probe_stall_o |-> !(l2_req_o && !l2_req_pf_o));
  p_req_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_o |=> !l2_req_o);
  p_harm_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    harm_cnt_o != $past(harm_cnt_o) |-> harm_cnt_o == $past(harm_cnt_o) + 1'b1);
  p_quiet_dem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_o && !l2_req_pf_o |-> !probe_hit_o && !probe_stall_o);
endmodule

bind ifetch_sbuf ifetch_sbuf_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .probe_valid_i(probe_valid_i),
  .probe_addr_i(probe_addr_i), .icache_hit_i(icache_hit_i),
  .probe_hit_o(probe_hit_o), .probe_stall_o(probe_stall_o),
  .fill_valid_o(fill_valid_o), .fill_addr_o(fill_addr_o),
  .l2_req_o(l2_req_o), .l2_req_pf_o(l2_req_pf_o), .harm_cnt_o(harm_cnt_o)
);

// File: tb/ifetch_sbuf_tb.sv
`timescale 1ns/1ps
module ifetch_sbuf_tb;
  localparam int D = 4, AW = 20, DW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, mode_lru_i = 1'b0;
  logic probe_valid_i = 1'b0, icache_hit_i = 1'b0, l2_resp_valid_i = 1'b0;
  logic [AW-1:0] probe_addr_i = '0;
  logic [DW-1:0] l2_resp_data_i = '0;
  logic probe_hit_o, probe_stall_o, fill_valid_o, l2_req_o, l2_req_pf_o;
  logic [AW-1:0] fill_addr_o, l2_req_addr_o;
  logic [DW-1:0] fill_data_o;
  logic [CW-1:0] harm_cnt_o;

  always #2.5 clk = ~clk;

  ifetch_sbuf #(.DEPTH(D), .AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

  typedef struct {bit v; logic [AW-1:0] a; logic [DW-1:0] d; bit p; bit r;} rec_t;
  rec_t fq[$];
  rec_t lq[$];

  bit m_mode, m_pfon, m_dw, m_drop, m_fv;
  int m_bus;
  logic [AW-1:0] m_nxt, m_da, m_fa;
  logic [DW-1:0] m_fd;
  logic [CW-1:0] m_harm;
  bit c_dout, c_pv, c_match, c_mp, c_hit, c_stall, c_miss, c_xfer;
  bit c_dgo, c_pfgo, c_skip, c_req;
  int c_mi;
  logic [AW-1:0] c_ra;

  int n_chk = 0, n_fail = 0, l2_left = 0;
  logic [AW-1:0] l2_a = '0, pc = '0;
  int unsigned seed = 32'h1234_5678;
  bit done = 1'b0;

  function automatic logic [DW-1:0] ldat(logic [AW-1:0] a);
    return DW'(a) * 32'h9E37 + 32'h51;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic m_reset(bit mode);
    rec_t e;
    m_mode = mode; m_pfon = 0; m_dw = 0; m_drop = 0; m_fv = 0; m_bus = 0;
    m_nxt = '0; m_da = '0; m_fa = '0; m_fd = '0; m_harm = '0;
    fq.delete(); lq.delete();
    for (int i = 0; i < D; i++) begin
      e.v = 0; e.a = '0; e.d = '0; e.p = 0; e.r = 1; lq.push_back(e);
    end
  endtask

  task automatic m_eval();
    bit room, dup, cond;
    c_dout = m_dw || m_bus == 1;
    c_pv = probe_valid_i && !c_dout;
    c_match = 0; c_mp = 0; c_mi = -1;
    if (!m_mode) begin
      if (fq.size() > 0 && fq[0].a == probe_addr_i) begin c_match = 1; c_mp = fq[0].p; c_mi = 0; end
    end else begin
      for (int i = 0; i < lq.size(); i++)
        if (lq[i].v && lq[i].a == probe_addr_i && !c_match) begin
          c_match = 1; c_mp = lq[i].p; c_mi = i;
        end
    end
    c_hit   = c_pv && c_match && !c_mp;
    c_stall = c_pv && !icache_hit_i && c_match && c_mp;
    c_miss  = c_pv && !icache_hit_i && !c_match;
    c_xfer  = c_hit && !icache_hit_i;
    room = 0; dup = 0;
    if (m_mode) begin
      foreach (lq[i]) begin
        if (lq[i].r) room = 1;
        if (lq[i].v && lq[i].a == m_nxt) dup = 1;
      end
    end else room = fq.size() < D;
    cond   = m_bus == 0 && !m_dw && m_pfon && !c_miss && !c_xfer && room;
    c_dgo  = m_bus == 0 && m_dw;
    c_skip = cond && dup;
    c_pfgo = cond && !dup;
    c_req  = c_dgo || c_pfgo;
    c_ra   = c_dgo ? m_da : m_nxt;
  endtask

  task automatic m_step(bit resp, logic [DW-1:0] rdat, logic [AW-1:0] pa);
    int ob = m_bus;
    rec_t e;
    if (m_dw && ob == 2) m_harm++;
    m_fv = 0;
    if (resp && ob != 0) begin
      if (ob == 1) begin m_fv = 1; m_fa = m_da; m_fd = rdat; end
      else if (!m_drop) begin
        if (!m_mode) begin fq[fq.size()-1].p = 0; fq[fq.size()-1].d = rdat; end
        else foreach (lq[i]) if (lq[i].p) begin lq[i].p = 0; lq[i].d = rdat; end
      end
      m_bus = 0; m_drop = 0;
    end else if (c_dgo) begin
      m_bus = 1; m_dw = 0;
    end else if (c_pfgo) begin
      m_bus = 2;
      e.v = 1; e.a = m_nxt; e.d = '0; e.p = 1; e.r = 0;
      if (!m_mode) fq.push_back(e);
      else begin
        for (int i = lq.size() - 1; i >= 0; i--)
          if (lq[i].r) begin lq.delete(i); break; end
        lq.push_front(e);
      end
      m_nxt++;
    end
    if (c_skip) m_nxt++;
    if (c_xfer) begin
      m_fv = 1;
      if (!m_mode) begin m_fa = fq[0].a; m_fd = fq[0].d; void'(fq.pop_front()); end
      else begin
        e = lq[c_mi]; m_fa = e.a; m_fd = e.d; e.r = 1;
        lq.delete(c_mi); lq.push_front(e);
      end
    end
    if (c_miss) begin
      m_dw = 1; m_da = pa; m_nxt = pa + 1'b1; m_pfon = 1;
      if (!m_mode) begin
        fq.delete();
        if (ob == 2 && !resp) m_drop = 1;
      end else foreach (lq[i]) lq[i].r = 1;
    end
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cycle_body();
    int unsigned r;
    bit sreq, sresp;
    logic [AW-1:0] sa, spa;
    logic [DW-1:0] sdat;
    string tg;
    r = rnd();
    if (r % 48 == 0) pc = AW'((r >> 8) % 64);
    probe_valid_i   = (r % 8) != 0;
    icache_hit_i    = ((r >> 3) % 4) == 0;
    probe_addr_i    = pc;
    l2_resp_valid_i = (l2_left == 1);
    l2_resp_data_i  = (l2_left == 1) ? ldat(l2_a) : '0;
    #1;
    m_eval();
    tg = (c_dout && probe_valid_i) ? "R9" : (m_mode ? "R4" : "R3");
    chk(probe_hit_o == c_hit, {"R1 ", tg}, "probe_hit", probe_hit_o, c_hit);
    chk(probe_stall_o == c_stall, {"R8 ", tg}, "probe_stall", probe_stall_o, c_stall);
    chk(fill_valid_o == m_fv, "R2", "fill_valid", fill_valid_o, m_fv);
    if (m_fv) begin
      chk(fill_addr_o == m_fa, "R2", "fill_addr", fill_addr_o, m_fa);
      chk(fill_data_o == m_fd, "R2", "fill_data", fill_data_o, m_fd);
    end
    chk(l2_req_o == c_req, c_dgo ? "R5" : "R6", "l2_req", l2_req_o, c_req);
    if (c_req) begin
      chk(l2_req_addr_o == c_ra, c_dgo ? "R5" : "R6", "l2_addr", l2_req_addr_o, c_ra);
      chk(l2_req_pf_o == c_pfgo, "R5", "l2_pf", l2_req_pf_o, c_pfgo);
    end
    chk(harm_cnt_o == m_harm, "R7", "harm_cnt", harm_cnt_o, m_harm);
    sreq = l2_req_o; sa = l2_req_addr_o; sresp = l2_resp_valid_i;
    sdat = l2_resp_data_i; spa = probe_addr_i;
    if (c_pv && !c_stall) pc = pc + 1'b1;
    @(posedge clk);
    m_step(sresp, sdat, spa);
    if (sresp) l2_left = 0;
    else if (l2_left > 1) l2_left--;
    if (sreq) begin l2_left = 3 + int'(sa % 4); l2_a = sa; end
    @(negedge clk);
  endtask

  task automatic run(bit mode, int ncyc);
    @(negedge clk);
    rst_n = 1'b0; mode_lru_i = mode;
    probe_valid_i = 0; icache_hit_i = 0; l2_resp_valid_i = 0; l2_left = 0;
    pc = AW'(16);
    repeat (3) @(negedge clk);
    #1;
    // R10: quiet outputs while in reset
    chk(probe_hit_o == 0 && probe_stall_o == 0, "R10", "reset probe", probe_hit_o, 0);
    chk(fill_valid_o == 0, "R10", "reset fill", fill_valid_o, 0);
    chk(l2_req_o == 0, "R10", "reset req", l2_req_o, 0);
    chk(harm_cnt_o == 0, "R10", "reset harm", harm_cnt_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mode_lru_i = !mode; // R10: must not take effect until the next reset
    m_reset(mode);
    for (int k = 0; k < ncyc; k++) cycle_body();
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    run(1'b0, 4000);
    run(1'b1, 4000);
    run(1'b0, 1500);
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule